// File: doc/BRIEF.md
# Serial Port Control and Status Logic

This block holds the control register and the status flags of a serial port that works either asynchronously or with a shared shift clock. A CPU writes one 8-bit control word through a plain write strobe and reads it back. That word turns the clock and data pin drivers on or off, enables the receiver and the transmitter, and sets three interrupt masks. The shift engines and baud generation sit outside the block. They report their events as single-cycle input pulses: a frame received with its parity and framing results, transmit data taken, and a transmission finished. The CPU side reports a read of the receive data and a load of the transmit data.

The block keeps six flags: parity error, overrun error, framing error, receive full, transmit complete and transmit empty. From these flags and the masks it forms a receive and a transmit interrupt request. When software turns the receiver or the transmitter off, the block sends a one-cycle abort strobe to that engine. Turning the transmitter off also forces both transmit flags to 1. The block has no data stream of its own, so every port is a plain level or pulse with no handshake.

Top module: `sport_ctl`

## Requirements
- R1: After reset `reg_rdata` is 0x20 and `status` is 6'b000001. A write stores `reg_wdata` and takes effect on the next clock edge. Bit 5 of `reg_rdata` always reads 1. The control bit positions are: 7 clock pin enable, 6 data pin enable, 5 error clear, 4 receive enable, 3 transmit enable, 2 receive interrupt mask, 1 transmit-complete mask, 0 transmit-empty mask.
- R2: A write with bit 5 = 0 clears the parity, overrun and framing flags (`status[5]`, `status[4]`, `status[3]`). A write with bit 5 = 1 leaves them unchanged. If an error event arrives in the same cycle as the clear, the event wins.
- R3: While the receiver is enabled, `rx_done` sets receive full (`status[2]`) and loads parity (`status[5]`) from `rx_par_err` and framing (`status[3]`) from `rx_frm_err`. If receive full is already set and `rx_read` is low, the event sets overrun (`status[4]`) instead and changes nothing else. `rx_read` clears receive full.
- R4: A write that turns the receive enable from 1 to 0 raises `rx_abort` for exactly the following cycle and changes no flag. Receive events that arrive while the receiver is disabled are ignored.
- R5: While the transmitter is enabled, `tx_taken` sets transmit empty (`status[0]`) and `tx_done` sets transmit complete (`status[1]`). `tx_load` clears both flags. A set in the same cycle wins over a clear. Transmit events that arrive while the transmitter is disabled are ignored.
- R6: A write that turns the transmit enable from 1 to 0 raises `tx_abort` for exactly the following cycle and sets both `status[1]` and `status[0]` to 1, even if `tx_load` arrives in the same cycle.
- R7: `rx_irq` is 1 exactly when control bit 2 is 1 and at least one of `status[5:2]` is 1.
- R8: `tx_irq` is 1 exactly when control bit 1 and `status[1]` are both 1, or control bit 0 and `status[0]` are both 1.
- R9: `sck_oe` is 1 when control bit 7 is 1, unless `sync_mode` and `ext_clk` are both 1. `sck_out` follows `shift_clk` in synchronous mode and is held at 1 in asynchronous mode.
- R10: `sdo_oe` equals control bit 6. `sdo_out` follows `ser_data` when that bit is 1 and is held at 1 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Control register write strobe |
| reg_wdata | input | 8 | Control write data |
| reg_rdata | output | 8 | Control readback, bit 5 always 1 |
| rx_done | input | 1 | Receiver finished a frame |
| rx_par_err | input | 1 | Parity error on that frame |
| rx_frm_err | input | 1 | Framing error on that frame |
| rx_read | input | 1 | CPU read the receive data |
| tx_load | input | 1 | CPU loaded the transmit data |
| tx_taken | input | 1 | Transmitter took the data |
| tx_done | input | 1 | Transmission finished |
| sync_mode | input | 1 | 1 = clock-synchronous mode |
| ext_clk | input | 1 | 1 = shift clock comes from outside |
| shift_clk | input | 1 | Internal shift clock |
| ser_data | input | 1 | Serial data from the transmitter |
| status | output | 6 | {par, ovr, frm, rx_full, tx_cmp, tx_empty} |
| rx_en | output | 1 | Receive enable to the engine |
| tx_en | output | 1 | Transmit enable to the engine |
| rx_abort | output | 1 | One-cycle receiver abort strobe |
| tx_abort | output | 1 | One-cycle transmitter abort strobe |
| rx_irq | output | 1 | Receive interrupt request |
| tx_irq | output | 1 | Transmit interrupt request |
| sck_out | output | 1 | Clock pin value |
| sck_oe | output | 1 | Clock pin drive enable |
| sdo_out | output | 1 | Data pin value |
| sdo_oe | output | 1 | Data pin drive enable |

## Verification
Every output comes straight from a register or from a single layer of gates over registers and inputs. A wrong flag or control bit therefore shows on `status`, `reg_rdata` or an interrupt request in the first cycle after the edge that stored it. A lost or stretched abort strobe appears in the cycle that follows the disabling write. Comparing each output against a reference model on every clock catches any fault within one cycle of its cause.

// File: rtl/sport_pkg.sv
package sport_pkg;
  localparam int REG_W = 8;
  localparam int FLG_W = 6;

  localparam int B_SCK  = 7;
  localparam int B_SDO  = 6;
  localparam int B_ECLR = 5;
  localparam int B_RXE  = 4;
  localparam int B_TXE  = 3;
  localparam int B_RIE  = 2;
  localparam int B_TCIE = 1;
  localparam int B_TEIE = 0;

  typedef struct packed {
    logic par;
    logic ovr;
    logic frm;
    logic rxf;
    logic tcmp;
    logic temp;
  } sport_flags_t;

  localparam sport_flags_t FLAGS_RST = '{par:1'b0, ovr:1'b0, frm:1'b0,
                                         rxf:1'b0, tcmp:1'b0, temp:1'b1};
endpackage

// File: rtl/sport_ctrl_reg.sv
module sport_ctrl_reg
  import sport_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic [REG_W-1:0] wdata,
  output logic [REG_W-1:0] ctrl,
  output logic             err_clr,
  output logic             tx_kill,
  output logic             rx_abort,
  output logic             tx_abort
);
  logic [REG_W-1:0] ctrl_q;
  logic             rx_kill;

  assign rx_kill = wr && ctrl_q[B_RXE] && !wdata[B_RXE];
  assign tx_kill = wr && ctrl_q[B_TXE] && !wdata[B_TXE];
  assign err_clr = wr && !wdata[B_ECLR];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q   <= '0;
      rx_abort <= 1'b0;
      tx_abort <= 1'b0;
    end else begin
      if (wr) ctrl_q <= wdata;
      rx_abort <= rx_kill;
      tx_abort <= tx_kill;
    end
  end

  always_comb begin
    ctrl         = ctrl_q;
    ctrl[B_ECLR] = 1'b1;
  end
endmodule

// File: rtl/sport_flags.sv
module sport_flags
  import sport_pkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  input  logic         rx_en,
  input  logic         tx_en,
  input  logic         err_clr,
  input  logic         tx_kill,
  input  logic         rx_done,
  input  logic         rx_par_err,
  input  logic         rx_frm_err,
  input  logic         rx_read,
  input  logic         tx_load,
  input  logic         tx_taken,
  input  logic         tx_done,
  output sport_flags_t flags
);
  sport_flags_t f_q, f_d;
  logic frame_ok, ovr_ev, new_frame;

  always_comb begin
    frame_ok  = rx_done && rx_en;
    ovr_ev    = frame_ok && f_q.rxf && !rx_read;
    new_frame = frame_ok && !ovr_ev;

    f_d.rxf  = new_frame || (f_q.rxf && !rx_read);
    f_d.par  = (new_frame && rx_par_err) || (f_q.par && !err_clr);
    f_d.frm  = (new_frame && rx_frm_err) || (f_q.frm && !err_clr);
    f_d.ovr  = ovr_ev || (f_q.ovr && !err_clr);
    f_d.temp = tx_kill || (tx_en && tx_taken) || (f_q.temp && !tx_load);
    f_d.tcmp = tx_kill || (tx_en && tx_done)  || (f_q.tcmp && !tx_load);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) f_q <= FLAGS_RST;
    else        f_q <= f_d;
  end

  assign flags = f_q;
endmodule

// File: rtl/sport_irq.sv
module sport_irq
  import sport_pkg::*;
(
  input  sport_flags_t flags,
  input  logic         rie,
  input  logic         tcie,
  input  logic         teie,
  output logic         rx_irq,
  output logic         tx_irq
);
  assign rx_irq = rie && (flags.rxf || flags.par || flags.ovr || flags.frm);
  assign tx_irq = (tcie && flags.tcmp) || (teie && flags.temp);
endmodule

// File: rtl/sport_pins.sv
module sport_pins (
  input  logic sck_en,
  input  logic sdo_en,
  input  logic sync_mode,
  input  logic ext_clk,
  input  logic shift_clk,
  input  logic ser_data,
  output logic sck_out,
  output logic sck_oe,
  output logic sdo_out,
  output logic sdo_oe
);
  assign sck_oe  = sck_en && !(sync_mode && ext_clk);
  assign sck_out = sync_mode ? shift_clk : 1'b1;
  assign sdo_oe  = sdo_en;
  assign sdo_out = sdo_en ? ser_data : 1'b1;
endmodule

// File: rtl/sport_ctl.sv
module sport_ctl
  import sport_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic [REG_W-1:0] reg_wdata,
  output logic [REG_W-1:0] reg_rdata,
  input  logic             rx_done,
  input  logic             rx_par_err,
  input  logic             rx_frm_err,
  input  logic             rx_read,
  input  logic             tx_load,
  input  logic             tx_taken,
  input  logic             tx_done,
  input  logic             sync_mode,
  input  logic             ext_clk,
  input  logic             shift_clk,
  input  logic             ser_data,
  output logic [FLG_W-1:0] status,
  output logic             rx_en,
  output logic             tx_en,
  output logic             rx_abort,
  output logic             tx_abort,
  output logic             rx_irq,
  output logic             tx_irq,
  output logic             sck_out,
  output logic             sck_oe,
  output logic             sdo_out,
  output logic             sdo_oe
);
  logic [REG_W-1:0] ctrl;
  logic             err_clr, tx_kill;
  sport_flags_t     flags;

  sport_ctrl_reg u_reg (
    .clk(clk), .rst_n(rst_n), .wr(reg_wr), .wdata(reg_wdata),
    .ctrl(ctrl), .err_clr(err_clr), .tx_kill(tx_kill),
    .rx_abort(rx_abort), .tx_abort(tx_abort)
  );

  assign rx_en = ctrl[B_RXE];
  assign tx_en = ctrl[B_TXE];

  sport_flags u_flags (
    .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .tx_en(tx_en),
    .err_clr(err_clr), .tx_kill(tx_kill),
    .rx_done(rx_done), .rx_par_err(rx_par_err), .rx_frm_err(rx_frm_err),
    .rx_read(rx_read), .tx_load(tx_load), .tx_taken(tx_taken),
    .tx_done(tx_done), .flags(flags)
  );

  sport_irq u_irq (
    .flags(flags), .rie(ctrl[B_RIE]), .tcie(ctrl[B_TCIE]), .teie(ctrl[B_TEIE]),
    .rx_irq(rx_irq), .tx_irq(tx_irq)
  );

  sport_pins u_pins (
    .sck_en(ctrl[B_SCK]), .sdo_en(ctrl[B_SDO]), .sync_mode(sync_mode),
    .ext_clk(ext_clk), .shift_clk(shift_clk), .ser_data(ser_data),
    .sck_out(sck_out), .sck_oe(sck_oe), .sdo_out(sdo_out), .sdo_oe(sdo_oe)
  );

  assign status    = flags;
  assign reg_rdata = ctrl;
endmodule

// File: rtl/sport_ctl_chk.sv
module sport_ctl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       reg_wr,
  input logic [7:0] reg_wdata,
  input logic [7:0] reg_rdata,
  input logic       rx_done,
  input logic       sync_mode,
  input logic       ext_clk,
  input logic [5:0] status,
  input logic       rx_en,
  input logic       tx_en,
  input logic       rx_abort,
  input logic       tx_abort,
  input logic       rx_irq,
  input logic       sck_oe
);
  AST_ECLR_READS_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rdata[5]); // R1

  AST_ERR_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && !reg_wdata[5] && !rx_done) |=> (status[5:3] == 3'b000)); // R2

  AST_RX_ABORT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rx_abort |-> (!rx_en && $fell(rx_en))); // R4

  AST_RX_ABORT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    rx_abort |=> !rx_abort); // R4

  AST_TX_OFF_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    tx_abort |-> (!tx_en && status[1:0] == 2'b11)); // R6

  AST_TX_ABORT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    tx_abort |=> !tx_abort); // R6

  AST_RX_IRQ_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    rx_irq |-> (status[5:2] != 4'b0000)); // R7

  AST_EXT_CLK_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_mode && ext_clk) |-> !sck_oe); // R9
endmodule

bind sport_ctl sport_ctl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
  .reg_rdata(reg_rdata), .rx_done(rx_done), .sync_mode(sync_mode),
  .ext_clk(ext_clk), .status(status), .rx_en(rx_en), .tx_en(tx_en),
  .rx_abort(rx_abort), .tx_abort(tx_abort), .rx_irq(rx_irq), .sck_oe(sck_oe)
);

// File: tb/sim_sport_ctl.sv
module sim_sport_ctl;
  localparam int CLK_PERIOD = 10;
  localparam int RAND_CYCLES = 6000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_wr = 0, rx_done = 0, rx_par_err = 0, rx_frm_err = 0, rx_read = 0;
  logic tx_load = 0, tx_taken = 0, tx_done = 0;
  logic sync_mode = 0, ext_clk = 0, shift_clk = 0, ser_data = 0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic [5:0] status;
  logic rx_en, tx_en, rx_abort, tx_abort, rx_irq, tx_irq;
  logic sck_out, sck_oe, sdo_out, sdo_oe;

  int n_tests = 0;
  int n_fail = 0;
  bit finished = 0;

  // reference model state
  bit [7:0] m_ctrl;
  bit m_par, m_ovr, m_frm, m_rxf, m_tcmp, m_temp, m_rxab, m_txab;

  always #(CLK_PERIOD/2) clk = ~clk;

  sport_ctl u0 (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .rx_done(rx_done), .rx_par_err(rx_par_err),
    .rx_frm_err(rx_frm_err), .rx_read(rx_read), .tx_load(tx_load),
    .tx_taken(tx_taken), .tx_done(tx_done), .sync_mode(sync_mode),
    .ext_clk(ext_clk), .shift_clk(shift_clk), .ser_data(ser_data),
    .status(status), .rx_en(rx_en), .tx_en(tx_en), .rx_abort(rx_abort),
    .tx_abort(tx_abort), .rx_irq(rx_irq), .tx_irq(tx_irq),
    .sck_out(sck_out), .sck_oe(sck_oe), .sdo_out(sdo_out), .sdo_oe(sdo_oe)
  );

  // behavioural reference, updated on each rising edge
  always @(posedge clk) begin
    if (!rst_n) begin
      m_ctrl = 8'h00;
      {m_par, m_ovr, m_frm, m_rxf, m_tcmp} = '0;
      m_temp = 1; m_rxab = 0; m_txab = 0;
    end else begin
      bit rxon, txon, clr, overrun, fresh, txoff;
      rxon  = m_ctrl[4];
      txon  = m_ctrl[3];
      clr   = reg_wr && (reg_wdata[5] == 0);
      txoff = reg_wr && txon && !reg_wdata[3];
      m_rxab = reg_wr && rxon && !reg_wdata[4];
      m_txab = txoff;
      overrun = 0; fresh = 0;
      if (rx_done && rxon) begin
        if (m_rxf && !rx_read) overrun = 1;
        else fresh = 1;
      end
      if (clr) begin m_par = 0; m_ovr = 0; m_frm = 0; end
      if (rx_read) m_rxf = 0;
      if (fresh) begin
        m_rxf = 1;
        if (rx_par_err) m_par = 1;
        if (rx_frm_err) m_frm = 1;
      end
      if (overrun) m_ovr = 1;
      if (tx_load) begin m_temp = 0; m_tcmp = 0; end
      if (txon && tx_taken) m_temp = 1;
      if (txon && tx_done) m_tcmp = 1;
      if (txoff) begin m_temp = 1; m_tcmp = 1; end
      if (reg_wr) m_ctrl = reg_wdata;
    end
  end

  task automatic chk(string tag, string what, int act, int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    bit [7:0] rd;
    bit ri, ti, soe, sout, doe, dout;
    rd = m_ctrl; rd[5] = 1;
    ri = m_ctrl[2] && (m_par || m_ovr || m_frm || m_rxf);
    ti = (m_ctrl[1] && m_tcmp) || (m_ctrl[0] && m_temp);
    soe  = m_ctrl[7] && !(sync_mode && ext_clk);
    sout = sync_mode ? shift_clk : 1'b1;
    doe  = m_ctrl[6];
    dout = doe ? ser_data : 1'b1;
    chk("R1", "reg_rdata", reg_rdata, rd);
    chk("R2", "error flags", status[5:3], {m_par, m_ovr, m_frm});
    chk("R3", "rx_full", status[2], m_rxf);
    chk("R4", "rx_en/rx_abort", {rx_en, rx_abort}, {m_ctrl[4], m_rxab});
    chk("R5", "tx flags", status[1:0], {m_tcmp, m_temp});
    chk("R6", "tx_en/tx_abort", {tx_en, tx_abort}, {m_ctrl[3], m_txab});
    chk("R7", "rx_irq", rx_irq, ri);
    chk("R8", "tx_irq", tx_irq, ti);
    chk("R9", "sck_oe", sck_oe, soe);
    if (soe) chk("R9", "sck_out", sck_out, sout);
    chk("R10", "sdo", {sdo_oe, sdo_out}, {doe, dout});
  endtask

  task automatic idle();
    reg_wr = 0; rx_done = 0; rx_par_err = 0; rx_frm_err = 0; rx_read = 0;
    tx_load = 0; tx_taken = 0; tx_done = 0;
  endtask

  // one cycle: compare at the falling edge, then drive the next inputs
  task automatic cyc();
    @(negedge clk);
    compare_all();
    idle();
  endtask

  task automatic wr(input logic [7:0] v);
    reg_wr = 1; reg_wdata = v;
    cyc();
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    idle();
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state: rdata 0x20, status 000001
    cyc();
    chk("R1", "reset rdata", reg_rdata, 8'h20);
    chk("R1", "reset status", status, 6'b000001);
    // enable all, no error clear
    wr(8'hFF);
    // R3: frame with parity error, then overrun
    rx_done = 1; rx_par_err = 1; cyc();
    rx_done = 1; cyc();
    chk("R3", "overrun set", status[5:2], 4'b1101);
    // R2: write 1 to bit 5 keeps errors, write 0 clears
    wr(8'hFF); wr(8'hDF);
    chk("R2", "errors cleared", status[5:3], 3'b000);
    // R2: event wins over clear
    rx_read = 1; cyc();
    reg_wr = 1; reg_wdata = 8'hDF; rx_done = 1; rx_frm_err = 1; cyc();
    chk("R2", "event beats clear", status[3], 1);
    // R4: rx disable keeps flags, ignores events
    wr(8'hEF);
    chk("R4", "rx_abort pulse", rx_abort, 1);
    chk("R4", "flags kept", status[5:2], 4'b0011);
    rx_read = 1; cyc();
    rx_done = 1; cyc();
    chk("R4", "ignored when off", status[2], 0);
    // R5/R6: load, disable with load in the same cycle
    tx_load = 1; cyc();
    chk("R5", "load clears", status[1:0], 2'b00);
    reg_wr = 1; reg_wdata = 8'hE7; tx_load = 1; cyc();
    chk("R6", "disable sets flags", status[1:0], 2'b11);
    chk("R6", "tx_abort pulse", tx_abort, 1);
    cyc();
    chk("R6", "abort one cycle", tx_abort, 0);
    // R9 modes
    wr(8'hF8);
    sync_mode = 1; ext_clk = 1; cyc();
    ext_clk = 0; shift_clk = 0; cyc();
    shift_clk = 1; cyc();
    sync_mode = 0; cyc();
    // randomised traffic
    for (int i = 0; i < RAND_CYCLES; i++) begin
      reg_wr     = ($urandom_range(0, 9) == 0);
      reg_wdata  = 8'($urandom);
      rx_done    = ($urandom_range(0, 3) == 0);
      rx_par_err = $urandom_range(0, 1);
      rx_frm_err = ($urandom_range(0, 2) == 0);
      rx_read    = ($urandom_range(0, 3) == 0);
      tx_load    = ($urandom_range(0, 4) == 0);
      tx_taken   = ($urandom_range(0, 4) == 0);
      tx_done    = ($urandom_range(0, 5) == 0);
      if ((i % 256) == 0) begin
        sync_mode = $urandom_range(0, 1);
        ext_clk   = $urandom_range(0, 1);
      end
      shift_clk = $urandom_range(0, 1);
      ser_data  = $urandom_range(0, 1);
      @(negedge clk);
      compare_all();
    end
    idle();
    cyc();
    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule